// File: doc/BRIEF.md
# Outstanding Request Tag Table

This block sits in a bridge that carries local-bus transactions across a packet network. When a request that expects an answer arrives from the network, the block records who sent it (the requester's 48-bit network address) and the transaction tag it carried, in a table of 32 entries, one per tag value. If the incoming tag is already held by another request still in flight, the block hands out a different free tag. The request then travels on the local side under that tag. Requests that expect no answer (posted writes) pass straight through and leave nothing behind.

When the local side later produces the answer, the block looks the answer's tag up in the table. It returns the stored network address, to be used as the destination of the outgoing answer frame, and the original tag the requester used, which undoes any remap. The entry is released in the same cycle as the lookup. A lookup that finds no entry raises an error pulse and produces nothing else.

A two-state controller tracks whether any tag is free. In state `ST_OPEN` the request port is ready. Transition `T_FILL` moves it to `ST_FULL` when the last free tag is taken and nothing is released in the same cycle. In `ST_FULL` the request port is not ready. Transition `T_DRAIN` returns it to `ST_OPEN` when any entry is released.

Top module: `tag_remap_table`

## Requirements
- R1: After reset `req_ready` is 1, `cap_valid`, `out_valid` and `out_err` are 0, and the table holds no entries.
- R2: A request of kind read (`2'b00`), non-posted write (`2'b10`) or atomic read-modify-write (`2'b11`), accepted while `req_valid` and `req_ready` are both 1, is stored. In the next cycle `cap_valid` is 1 and `cap_stored` is 1.
- R3: A posted write (`req_kind` `2'b01`) stores nothing. In the next cycle `cap_valid` is 1, `cap_stored` is 0 and `cap_tag` equals the incoming tag. A later lookup of that tag reports a miss.
- R4: A stored request whose tag is not held by any entry keeps its tag: `cap_tag` equals `req_tag`.
- R5: A stored request whose tag is already held is given the lowest-numbered free tag, reported on `cap_tag`.
- R6: A lookup (`rsp_valid` with `rsp_tag`) that hits an entry gives, in the next cycle, `out_valid` 1, `out_mac` equal to the stored address and `out_tag` equal to the original tag of the request.
- R7: A hit releases its entry at the same clock edge. A second lookup of the same tag misses, and the tag is free for a new request.
- R8: A lookup of a tag with no entry gives, in the next cycle, `out_err` 1 and `out_valid` 0.
- R9: When all 32 entries are held, `req_ready` is 0 and an offered request is ignored (no `cap_valid`, table unchanged). One cycle after an entry is released, `req_ready` is 1 again.
- R10: When a request and a hit happen in the same cycle, tag choice for the request uses the occupancy from before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Incoming request offered |
| req_ready | output | 1 | Request can be accepted (a tag is free) |
| req_kind | input | 2 | 00 read, 01 posted write, 10 non-posted write, 11 atomic |
| req_tag | input | 5 | Tag carried by the incoming request |
| req_mac | input | 48 | Network address of the requester |
| cap_valid | output | 1 | Capture result valid (one cycle after acceptance) |
| cap_tag | output | 5 | Tag to use on the local side |
| cap_stored | output | 1 | An entry was made for this request |
| rsp_valid | input | 1 | Outgoing answer to be looked up |
| rsp_tag | input | 5 | Tag of the outgoing answer |
| out_valid | output | 1 | Lookup hit result valid |
| out_tag | output | 5 | Original tag restored for the answer |
| out_mac | output | 48 | Destination network address for the answer |
| out_err | output | 1 | Lookup missed, answer discarded |

## Verification
The capture path is driven with a fresh tag, the same tag repeated under all three answer-expecting kinds, and a posted write. This separates tag pass-through, remap to the lowest free tag and the no-store case. The lookup path is tried with hits, a repeated lookup and a never-used tag, which separates restoration of the original tag from release and from the miss flag. Filling all 32 tags, offering a request while full, then freeing one entry in the middle shows the back-pressure and that a lone free tag in the middle is found. A capture and a release of the same tag in one cycle shows which occupancy governs tag choice.

// File: rtl/tagtab_pkg.sv
package tagtab_pkg;

    typedef enum logic [1:0] {
        KIND_READ      = 2'b00,
        KIND_WR_POSTED = 2'b01,
        KIND_WR_NP     = 2'b10,
        KIND_ATOMIC    = 2'b11
    } req_kind_t;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_FULL = 1'b1
    } fill_state_t;

    // Every kind except a posted write receives an answer.
    function automatic logic needs_reply(req_kind_t k);
        return k != KIND_WR_POSTED;
    endfunction

endpackage

// File: rtl/tagtab_alloc.sv
module tagtab_alloc #(
    parameter int TAG_W = 5,
    localparam int DEPTH = 1 << TAG_W
) (
    input  logic [DEPTH-1:0] busy,
    input  logic [TAG_W-1:0] want,
    output logic [TAG_W-1:0] grant,
    output logic             any_free,
    output logic             last_free
);

    logic [TAG_W-1:0] lowest;

    always_comb begin
        lowest = '0;
        // Scan downwards so the smallest free index is the final assignment.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) lowest = TAG_W'(i);
        end
        grant     = busy[want] ? lowest : want;
        any_free  = ~&busy;
        last_free = ($countones(~busy) == 1);
    end

endmodule

// File: rtl/tagtab_store.sv
module tagtab_store #(
    parameter int TAG_W = 5,
    parameter int MAC_W = 48,
    localparam int DEPTH = 1 << TAG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_idx,
    input  logic [MAC_W-1:0] wr_mac,
    input  logic [TAG_W-1:0] wr_orig,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_idx,
    input  logic [TAG_W-1:0] rd_idx,
    output logic             rd_hit,
    output logic [MAC_W-1:0] rd_mac,
    output logic [TAG_W-1:0] rd_orig,
    output logic [DEPTH-1:0] busy
);

    logic [MAC_W-1:0] mac_q  [DEPTH];
    logic [TAG_W-1:0] orig_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        logic hit_wr;
        logic hit_clr;
        assign hit_wr  = wr_en  && (wr_idx  == TAG_W'(e));
        assign hit_clr = clr_en && (clr_idx == TAG_W'(e));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[e] <= 1'b0;
            end else if (hit_wr) begin
                busy[e] <= 1'b1;
            end else if (hit_clr) begin
                busy[e] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_wr) begin
                mac_q[e]  <= wr_mac;
                orig_q[e] <= wr_orig;
            end
        end
    end

    assign rd_hit  = busy[rd_idx];
    assign rd_mac  = mac_q[rd_idx];
    assign rd_orig = orig_q[rd_idx];

endmodule

// File: rtl/tag_remap_table.sv
module tag_remap_table
    import tagtab_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int MAC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [MAC_W-1:0] req_mac,
    output logic             cap_valid,
    output logic [TAG_W-1:0] cap_tag,
    output logic             cap_stored,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [MAC_W-1:0] out_mac,
    output logic             out_err
);

    localparam int DEPTH = 1 << TAG_W;

    fill_state_t      state_q, state_d;
    logic [DEPTH-1:0] busy;
    logic [TAG_W-1:0] grant;
    logic             any_free, last_free;
    logic             rd_hit;
    logic [MAC_W-1:0] rd_mac;
    logic [TAG_W-1:0] rd_orig;
    logic             req_fire, np, wr_en, clr_en;

    assign req_ready = (state_q == ST_OPEN);
    assign req_fire  = req_valid && req_ready;
    assign np        = needs_reply(req_kind_t'(req_kind));
    assign wr_en     = req_fire && np && any_free;
    assign clr_en    = rsp_valid && rd_hit;

    tagtab_alloc #(.TAG_W(TAG_W)) u_alloc (
        .busy      (busy),
        .want      (req_tag),
        .grant     (grant),
        .any_free  (any_free),
        .last_free (last_free)
    );

    tagtab_store #(.TAG_W(TAG_W), .MAC_W(MAC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (grant),
        .wr_mac  (req_mac),
        .wr_orig (req_tag),
        .clr_en  (clr_en),
        .clr_idx (rsp_tag),
        .rd_idx  (rsp_tag),
        .rd_hit  (rd_hit),
        .rd_mac  (rd_mac),
        .rd_orig (rd_orig),
        .busy    (busy)
    );

    // Next-state logic: T_FILL and T_DRAIN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (wr_en && last_free && !clr_en) state_d = ST_FULL;
            ST_FULL: if (clr_en)                        state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Registered outputs of both ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid  <= 1'b0;
            cap_tag    <= '0;
            cap_stored <= 1'b0;
            out_valid  <= 1'b0;
            out_tag    <= '0;
            out_mac    <= '0;
            out_err    <= 1'b0;
        end else begin
            cap_valid  <= req_fire;
            cap_tag    <= np ? grant : req_tag;
            cap_stored <= wr_en;
            out_valid  <= clr_en;
            out_tag    <= rd_orig;
            out_mac    <= rd_mac;
            out_err    <= rsp_valid && !rd_hit;
        end
    end

    // R9
    full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy) |-> !req_ready);

    // R5
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy[grant]);

    // R4
    keep_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && np && !busy[req_tag]) |=> (cap_tag == $past(req_tag)));

    // R3
    posted_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !np && !rsp_valid) |=> $stable(busy));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !busy[$past(rsp_tag)]);

    // R8
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !busy[rsp_tag]) |=> (out_err && !out_valid));

endmodule

// File: tb/tb_tag_remap_table.sv
module tb_tag_remap_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [4:0]  req_tag = '0;
    logic [47:0] req_mac = '0;
    logic        cap_valid;
    logic [4:0]  cap_tag;
    logic        cap_stored;
    logic        rsp_valid = 1'b0;
    logic [4:0]  rsp_tag = '0;
    logic        out_valid;
    logic [4:0]  out_tag;
    logic [47:0] out_mac;
    logic        out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the table, built from the requirements.
    bit          m_busy [32];
    logic [4:0]  m_orig [32];
    logic [47:0] m_mac  [32];

    always #5 clk = ~clk;

    tag_remap_table dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_tag(req_tag), .req_mac(req_mac),
        .cap_valid(cap_valid), .cap_tag(cap_tag), .cap_stored(cap_stored),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .out_valid(out_valid), .out_tag(out_tag), .out_mac(out_mac), .out_err(out_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] pick(input logic [4:0] want);
        if (!m_busy[want]) return want;
        for (int i = 0; i < 32; i++) if (!m_busy[i]) return 5'(i);
        return '0;
    endfunction

    task automatic do_req(input logic [1:0] kind, input logic [4:0] tag, input logic [47:0] mac, input string req);
        bit         st = (kind != 2'b01);
        logic [4:0] et = st ? pick(tag) : tag;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_tag = tag; req_mac = mac;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(cap_valid == 1'b1, req, cap_valid, 1);
        check(cap_stored == st, req, cap_stored, st);
        check(cap_tag == et, req, cap_tag, et);
        if (st) begin
            m_busy[et] = 1'b1; m_orig[et] = tag; m_mac[et] = mac;
        end
    endtask

    task automatic do_rsp(input logic [4:0] tag, input string req);
        bit hit = m_busy[tag];
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = tag;
        @(posedge clk); #1;
        rsp_valid = 1'b0;
        check(out_valid == hit, req, out_valid, hit);
        check(out_err == !hit, req, out_err, !hit);
        if (hit) begin
            check(out_tag == m_orig[tag], req, out_tag, m_orig[tag]);
            check(out_mac == m_mac[tag], req, out_mac, m_mac[tag]);
            m_busy[tag] = 1'b0;
        end
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(cap_valid == 1'b0, "R1 cap_valid", cap_valid, 0);
        check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        check(out_err == 1'b0, "R1 out_err", out_err, 0);
        do_rsp(5'd3, "R1 empty table lookup");
    endtask

    task automatic t_basic;
        do_req(2'b00, 5'd4, 48'h0A0B0C0D0E04, "R2 R4 read capture");
        do_rsp(5'd4, "R6 read lookup");
        do_rsp(5'd4, "R7 repeated lookup misses");
        do_rsp(5'd17, "R8 unused tag miss");
    endtask

    task automatic t_posted;
        do_req(2'b01, 5'd7, 48'h111111111107, "R3 posted pass-through");
        do_rsp(5'd7, "R3 posted left no entry");
    endtask

    task automatic t_collide;
        do_req(2'b00, 5'd2, 48'hB00000000001, "R4 fresh tag kept");
        do_req(2'b10, 5'd2, 48'hB00000000002, "R5 np write remapped to 0");
        do_req(2'b11, 5'd2, 48'hB00000000003, "R5 atomic remapped to 1");
        do_rsp(5'd0, "R6 restore tag from 0");
        do_rsp(5'd1, "R6 restore tag from 1");
        do_rsp(5'd2, "R6 unremapped entry");
    endtask

    task automatic t_full;
        for (int t = 0; t < 32; t++)
            do_req(2'b00, 5'(t), {43'h5A5A, 5'(t)}, "R9 fill");
        check(req_ready == 1'b0, "R9 ready low when full", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_tag = 5'd3; req_mac = 48'hDEAD;
        @(posedge clk); #1;
        req_valid = 1'b0;
        check(cap_valid == 1'b0, "R9 request ignored while full", cap_valid, 0);
        do_rsp(5'd9, "R9 release one");
        check(req_ready == 1'b1, "R9 ready after release", req_ready, 1);
        do_req(2'b10, 5'd20, 48'hC0FFEE000020, "R5 only free tag in middle");
        check(req_ready == 1'b0, "R9 full again", req_ready, 0);
        for (int t = 0; t < 32; t++)
            do_rsp(5'(t), "R9 drain");
        check(req_ready == 1'b1, "R9 ready after drain", req_ready, 1);
    endtask

    task automatic t_same_cycle;
        do_req(2'b00, 5'd5, 48'hE00000000005, "R10 setup");
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_tag = 5'd5; req_mac = 48'hE00000000055;
        rsp_valid = 1'b1; rsp_tag = 5'd5;
        @(posedge clk); #1;
        req_valid = 1'b0; rsp_valid = 1'b0;
        check(cap_tag == 5'd0, "R10 tag choice uses pre-release occupancy", cap_tag, 0);
        check(out_valid == 1'b1 && out_tag == 5'd5, "R10 release in same cycle", out_tag, 5);
        m_busy[5] = 1'b0;
        m_busy[0] = 1'b1; m_orig[0] = 5'd5; m_mac[0] = 48'hE00000000055;
        do_rsp(5'd0, "R10 remapped entry restores tag");
        do_rsp(5'd5, "R7 released tag misses");
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_busy[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_basic();
        t_posted();
        t_collide();
        t_full();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule